// File: doc/BRIEF.md
# Initialization-Block Base Address Registers with Pointer Extension

This block is a small register bank for a bus-master controller. It stores the 32-bit memory address of an initialization block in two 16-bit registers, a low half and a high half. Each half can also be reached at a second alias address. Software may change them only while the controller is stopped or suspended. The block also holds the INIT control bit. That bit is set by software and cleared by any reset or by the controller entering the stopped state.

The block also forms addresses for the bus master. With legacy 24-bit software structures selected (size mode 0), every 24-bit descriptor or buffer pointer gets the stored top byte of the base address as its upper byte. With 32-bit structures selected (size mode 1), pointers pass through unchanged, and the stored top byte extends only the initialization address.

The access state machine has three states. ACC_STOP is the reset state and is entered whenever `stop_i` is high. ACC_SUSP is entered when `spnd_i` is high and `stop_i` is low. ACC_RUN is entered when both inputs are low. The transitions are:
- enter-stop: any state to ACC_STOP.
- suspend: ACC_RUN or ACC_STOP to ACC_SUSP.
- resume: ACC_SUSP or ACC_STOP to ACC_RUN.

Each transition takes effect at the clock edge that samples the inputs.

Top module: `init_base_regs`

## Requirements
- R1: The low base register (register address 1) holds address bits 15:0. Its bits 1:0 always read 0, whatever value was written, so the block stays aligned to a 32-bit word.
- R2: The high base register (address 2) holds bits 23:16 in data bits 7:0 and bits 31:24 in data bits 15:8. `init_addr_o` equals {high, low} at all times.
- R3: A write to a base register (addresses 1 to 4) changes the register only when the registered access state is ACC_STOP or ACC_SUSP. While the state is ACC_RUN, such writes are ignored and base-register reads return 0. The state follows `stop_i` first, then `spnd_i`, one clock edge after they are sampled.
- R4: The base registers keep their contents through hard reset (`rst_n` low), soft reset (`soft_rst` high) and entry into ACC_STOP.
- R5: Address 3 is an alias of the low register and address 4 is an alias of the high register. A write through either address of a pair is read back through both addresses.
- R6: With `wide32_i` = 0, `ptr_o` = {stored bits 31:24, `ptr_i`[23:0]}.
- R7: With `wide32_i` = 1, `ptr_o` = `ptr_i`, and `init_addr_o` still carries the stored bits 31:24.
- R8: Writing address 0 with data bit 0 = 1 sets INIT (`init_o`). Writing it with bit 0 = 0 has no effect. INIT stays set until one of the clears in R9.
- R9: INIT is cleared by hard reset, by soft reset, and at the edge where the state enters ACC_STOP from another state.
- R10: Address 0 reads {15'b0, INIT}. Addresses 5 to 7 read 0, and writes to them change nothing.
- R11: `ign_wr_o` is high for exactly the one cycle after an edge at which a base-register write was presented in ACC_RUN. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| stop_i | input | 1 | Controller stop bit |
| spnd_i | input | 1 | Controller suspend bit |
| wide32_i | input | 1 | Structure size mode: 1 selects 32-bit pointers |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| init_o | output | 1 | INIT bit |
| ign_wr_o | output | 1 | Pulse for a base-register write rejected while running |
| init_addr_o | output | 32 | Full initialization-block address |
| ptr_i | input | 32 | Descriptor or buffer pointer to extend |
| ptr_o | output | 32 | Bus-master address formed from `ptr_i` |

## Verification
The pointer path is driven from a table that mixes both size modes with pointers whose upper byte is zero, all ones, or unrelated to the stored byte. This shows whether the stored top byte replaces only bits 31:24 in 24-bit mode and leaves the pointer untouched in 32-bit mode. Register writes are tried in all three access states, so an accepted write can be told apart from a dropped one and from a read that is masked while running. Directed sequences then separate the three ways INIT is cleared from its write-0 and hold behaviour, and confirm that the base registers survive each reset.

// File: rtl/init_base_pkg.sv
package init_base_pkg;
    typedef enum logic [1:0] {
        ACC_RUN  = 2'd0,
        ACC_STOP = 2'd1,
        ACC_SUSP = 2'd2
    } acc_state_e;

    localparam int unsigned RA_CTRL   = 0;
    localparam int unsigned RA_LO     = 1;
    localparam int unsigned RA_HI     = 2;
    localparam int unsigned RA_LO_ALS = 3;
    localparam int unsigned RA_HI_ALS = 4;
endpackage

// File: rtl/ibr_access_fsm.sv
module ibr_access_fsm
    import init_base_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_i,
    input  logic spnd_i,
    output logic unlocked_o,
    output logic stop_entry_o
);
    acc_state_e state_q, state_d;

    always_comb begin
        if (stop_i)      state_d = ACC_STOP;
        else if (spnd_i) state_d = ACC_SUSP;
        else             state_d = ACC_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        unlocked_o   = 1'b0;
        stop_entry_o = 1'b0;
        unique case (state_q)
            ACC_RUN:  stop_entry_o = (state_d == ACC_STOP);
            ACC_SUSP: begin
                unlocked_o   = 1'b1;
                stop_entry_o = (state_d == ACC_STOP);
            end
            ACC_STOP: unlocked_o = 1'b1;
            default:  unlocked_o = 1'b0;
        endcase
    end

    // R3: stop has priority and is reached one edge later
    p_stop_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (state_q == ACC_STOP));
    // R3: run state locks the bank
    p_run_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_i && !spnd_i) |=> !unlocked_o);
endmodule

// File: rtl/ibr_store.sv
module ibr_store
    import init_base_pkg::*;
#(
    parameter int unsigned DW    = 16,
    parameter int unsigned AW    = 3,
    parameter int unsigned ALIGN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          unlocked,
    input  logic          stop_entry,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] lo_o,
    output logic [DW-1:0] hi_o,
    output logic          init_o,
    output logic          ign_wr_o
);
    localparam logic [DW-1:0] ALIGN_MASK = {{(DW-ALIGN){1'b0}}, {ALIGN{1'b1}}};

    logic [DW-1:0] lo_q, hi_q;
    logic          init_q, ign_q;
    logic          sel_ctrl, sel_lo, sel_hi, sel_base, base_wr_ok;

    assign sel_ctrl   = (addr == AW'(RA_CTRL));
    assign sel_lo     = (addr == AW'(RA_LO)) || (addr == AW'(RA_LO_ALS));
    assign sel_hi     = (addr == AW'(RA_HI)) || (addr == AW'(RA_HI_ALS));
    assign sel_base   = sel_lo || sel_hi;
    assign base_wr_ok = wr_en && unlocked;

    // Address storage carries no reset: contents survive every reset kind.
    always_ff @(posedge clk) begin
        if (base_wr_ok && sel_lo) lo_q <= wdata & ~ALIGN_MASK;
        if (base_wr_ok && sel_hi) hi_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q <= 1'b0;
            ign_q  <= 1'b0;
        end else begin
            if (soft_rst || stop_entry)           init_q <= 1'b0;
            else if (wr_en && sel_ctrl && wdata[0]) init_q <= 1'b1;
            ign_q <= wr_en && sel_base && !unlocked;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_ctrl)                rdata = {{(DW-1){1'b0}}, init_q};
        else if (sel_lo && unlocked) rdata = lo_q;
        else if (sel_hi && unlocked) rdata = hi_q;
    end

    assign lo_o     = lo_q;
    assign hi_o     = hi_q;
    assign init_o   = init_q;
    assign ign_wr_o = ign_q;

    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> ($stable(lo_q) && $stable(hi_q)));
    p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && unlocked && sel_lo) |=> (lo_q[ALIGN-1:0] == '0));
    p_init_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (init_q && !soft_rst && !stop_entry) |=> init_q);
    p_stop_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_entry || soft_rst) |=> !init_q);
    p_ign_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ign_q |-> $past(wr_en));
endmodule

// File: rtl/ibr_addr_form.sv
module ibr_addr_form #(
    parameter int unsigned DW    = 16,
    parameter int unsigned PW    = 32,
    parameter int unsigned LEG_W = 24
) (
    input  logic [DW-1:0] lo_i,
    input  logic [DW-1:0] hi_i,
    input  logic          wide32_i,
    input  logic [PW-1:0] ptr_i,
    output logic [PW-1:0] init_addr_o,
    output logic [PW-1:0] ptr_o
);
    localparam int unsigned EXT_W = PW - LEG_W;

    logic [EXT_W-1:0] ext_byte;

    assign init_addr_o = {hi_i, lo_i};
    assign ext_byte    = init_addr_o[PW-1:LEG_W];

    generate
        if (EXT_W > 0) begin : g_ext
            assign ptr_o = wide32_i ? ptr_i : {ext_byte, ptr_i[LEG_W-1:0]};
        end else begin : g_noext
            assign ptr_o = ptr_i;
        end
    endgenerate
endmodule

// File: rtl/init_base_regs.sv
module init_base_regs #(
    parameter int unsigned DW    = 16,
    parameter int unsigned AW    = 3,
    parameter int unsigned PW    = 32,
    parameter int unsigned ALIGN = 2,
    parameter int unsigned LEG_W = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          stop_i,
    input  logic          spnd_i,
    input  logic          wide32_i,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          init_o,
    output logic          ign_wr_o,
    output logic [PW-1:0] init_addr_o,
    input  logic [PW-1:0] ptr_i,
    output logic [PW-1:0] ptr_o
);
    logic          unlocked, stop_entry;
    logic [DW-1:0] lo_w, hi_w;

    ibr_access_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_i       (stop_i),
        .spnd_i       (spnd_i),
        .unlocked_o   (unlocked),
        .stop_entry_o (stop_entry)
    );

    ibr_store #(.DW(DW), .AW(AW), .ALIGN(ALIGN)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .unlocked   (unlocked),
        .stop_entry (stop_entry),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .lo_o       (lo_w),
        .hi_o       (hi_w),
        .init_o     (init_o),
        .ign_wr_o   (ign_wr_o)
    );

    ibr_addr_form #(.DW(DW), .PW(PW), .LEG_W(LEG_W)) u_form (
        .lo_i        (lo_w),
        .hi_i        (hi_w),
        .wide32_i    (wide32_i),
        .ptr_i       (ptr_i),
        .init_addr_o (init_addr_o),
        .ptr_o       (ptr_o)
    );

    // R6: legacy pointers take their top byte from the base address
    p_ext_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wide32_i |-> (ptr_o[PW-1:LEG_W] == init_addr_o[PW-1:LEG_W]));
    // R7: wide pointers are not modified
    p_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wide32_i |-> (ptr_o == ptr_i));
endmodule

// File: tb/init_base_regs_bench.sv
module init_base_regs_bench;
    localparam int unsigned CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, soft_rst, stop_i, spnd_i, wide32_i, wr_en;
    logic [2:0]  addr;
    logic [15:0] wdata, rdata;
    logic        init_o, ign_wr_o;
    logic [31:0] init_addr_o, ptr_i, ptr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    init_base_regs u_init_base_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_i(stop_i),
        .spnd_i(spnd_i), .wide32_i(wide32_i), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .init_o(init_o), .ign_wr_o(ign_wr_o),
        .init_addr_o(init_addr_o), .ptr_i(ptr_i), .ptr_o(ptr_o)
    );

    // {wide32, ptr_i, expected ptr_o} with stored base 32'hA5C3_1234
    localparam logic [64:0] VEC [6] = '{
        {1'b0, 32'h0012_3456, 32'hA512_3456},
        {1'b0, 32'hFFFF_FFFF, 32'hA5FF_FFFF},
        {1'b0, 32'h7700_0000, 32'hA500_0000},
        {1'b1, 32'h0012_3456, 32'h0012_3456},
        {1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {1'b0, 32'hDEAD_BEEF, 32'hA5AD_BEEF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [15:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, {16'h0, rdata}, {16'h0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; soft_rst = 1'b0; stop_i = 1'b1; spnd_i = 1'b0;
        wide32_i = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; ptr_i = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset init", {31'h0, init_o}, 32'h0);
        check("R11 reset ign", {31'h0, ign_wr_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        rd("R10 ctrl reset", 3'd0, 16'h0000);

        // R1 / R2 base layout while stopped
        wr(3'd1, 16'h1237);
        rd("R1 align", 3'd1, 16'h1234);
        wr(3'd2, 16'hA5C3);
        rd("R2 high", 3'd2, 16'hA5C3);
        check("R2 init_addr", init_addr_o, 32'hA5C3_1234);

        // R5 aliases
        rd("R5 lo alias", 3'd3, 16'h1234);
        rd("R5 hi alias", 3'd4, 16'hA5C3);
        wr(3'd4, 16'h5A3C);
        rd("R5 alias write", 3'd2, 16'h5A3C);
        wr(3'd2, 16'hA5C3);

        // R6 / R7 table walk
        foreach (VEC[i]) begin
            @(negedge clk);
            wide32_i = VEC[i][64];
            ptr_i    = VEC[i][63:32];
            #1;
            check(VEC[i][64] ? "R7 wide ptr" : "R6 legacy ptr", ptr_o, VEC[i][31:0]);
            check("R7 init_addr", init_addr_o, 32'hA5C3_1234);
        end

        // R10 reserved bits and unused addresses; R8 write 0 no effect
        wr(3'd0, 16'hFFFE);
        rd("R10 ctrl reserved", 3'd0, 16'h0000);
        wr(3'd5, 16'hFFFF);
        rd("R10 unused addr", 3'd5, 16'h0000);
        rd("R10 no side write", 3'd1, 16'h1234);

        // R8 set and hold
        wr(3'd0, 16'h0001);
        check("R8 init set", {31'h0, init_o}, 32'h1);
        wr(3'd0, 16'h0000);
        repeat (4) @(posedge clk);
        #1;
        check("R8 init hold", {31'h0, init_o}, 32'h1);
        rd("R8 ctrl read", 3'd0, 16'h0001);

        // R3 / R11 running state
        @(negedge clk); stop_i = 1'b0; spnd_i = 1'b0;
        wr(3'd1, 16'h4444);
        check("R11 ign pulse", {31'h0, ign_wr_o}, 32'h1);
        @(posedge clk); #1;
        check("R11 ign one cycle", {31'h0, ign_wr_o}, 32'h0);
        rd("R3 masked read", 3'd1, 16'h0000);
        check("R3 run keeps init", {31'h0, init_o}, 32'h1);

        // R3 suspended state
        @(negedge clk); spnd_i = 1'b1;
        rd("R3 ignored write", 3'd1, 16'h1234);
        wr(3'd1, 16'h8888);
        check("R11 no pulse when open", {31'h0, ign_wr_o}, 32'h0);
        rd("R3 suspend write", 3'd1, 16'h8888);

        // R9 stop entry clears INIT; R4 contents kept
        @(negedge clk); stop_i = 1'b1;
        @(posedge clk); #1;
        check("R9 stop clear", {31'h0, init_o}, 32'h0);
        rd("R4 stop keep", 3'd1, 16'h8888);

        // R9 soft reset
        wr(3'd0, 16'h0001);
        @(negedge clk); soft_rst = 1'b1;
        @(posedge clk); #1;
        soft_rst = 1'b0;
        check("R9 soft clear", {31'h0, init_o}, 32'h0);
        rd("R4 soft keep", 3'd1, 16'h8888);

        // R9 hard reset
        wr(3'd0, 16'h0001);
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R9 hard clear", {31'h0, init_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        rd("R4 hard keep lo", 3'd1, 16'h8888);
        rd("R4 hard keep hi", 3'd2, 16'hA5C3);

        finish_run();
    end
endmodule